// File: doc/BRIEF.md
# Queue Interrupt Status Aggregator

This block gathers completion and error events from a set of transmit and receive endpoint queues and keeps them in registers that software reads and clears. Every queue engine sends one-cycle event pulses per endpoint: a done pulse, and error pulses for checksum failure, length mismatch and, on the receive side, a zero-length packet received. Done events are always latched. Error events are latched only where software has armed the matching bit in a per-endpoint error-enable register.

Software reads through a simple port with an address, write data, a write strobe and combinational read data. Status registers are cleared by writing 1 to a bit. The error registers are condensed into five exception summary bits. One interrupt line is the OR of the done status masked by a done-enable register and the summary bits masked by an exception-enable register. Endpoint 0 is a control endpoint with no queue, so it never raises a bit. The endpoint count is a parameter of at most 16.

Top module: `qisr_aggregator`

## Requirements
- R1: Register index 0 (done status) holds a transmit done event of endpoint k in bit k and a receive done event of endpoint k in bit 16+k. The bit is set on the clock edge that samples the pulse.
- R2: Writing 1 to a bit of index 0, 4, 6 or 8 clears that bit. A written 0 leaves the bit unchanged.
- R3: irq is high whenever a bit of index 0 and the same bit of index 1 (done enable) are both set.
- R4: Index 4 (transmit errors) holds a checksum error of endpoint k in bit k and a length error in bit 16+k. Each is latched only while the same bit of index 5 is set.
- R5: Index 6 holds receive checksum errors in bit k and receive length errors in bit 16+k, gated by index 7. Zero-length receive events of endpoint k go to bit k of index 8 instead, gated by bit k of index 9. They never appear in index 6.
- R6: Index 2 is read-only. Its bits are: bit0 any receive checksum error, bit1 any receive length error, bit2 any zero-length receive, bit3 any transmit checksum error, bit4 any transmit length error. Each bit follows the error registers and drops once those bits are cleared.
- R7: irq is also high whenever a bit of index 2 and the same bit of index 3 (exception enable) are both set.
- R8: Events for endpoint 0, and for endpoints at or above the endpoint count, never set any status bit.
- R9: When an event and a write-1 clear of the same status bit fall in the same cycle, the bit ends up set.
- R10: Indices 1, 3, 5, 7 and 9 read back what was written. Index 3 keeps bits 4:0 only, and index 9 keeps bits 15:0 only. Unused bits read 0.
- R11: After reset every register reads 0 and irq is low. Unmapped indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_done_evt | input | NUM_EP | Transmit done pulses, one per endpoint |
| rx_done_evt | input | NUM_EP | Receive done pulses |
| tx_cs_err_evt | input | NUM_EP | Transmit checksum error pulses |
| tx_len_err_evt | input | NUM_EP | Transmit length error pulses |
| rx_cs_err_evt | input | NUM_EP | Receive checksum error pulses |
| rx_len_err_evt | input | NUM_EP | Receive length error pulses |
| rx_zlp_evt | input | NUM_EP | Receive zero-length packet pulses |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Interrupt line |

## Verification
The functions that can meet in one cycle are event latching and software's write-1 clear of the same status word. The bench provokes this by driving a done pulse on one endpoint in the same cycle as a write that clears that bit and another set bit. It then reads the word back and expects the pulsed bit set and the other bit cleared. The same cycle-level model is used to judge the summary bits and the interrupt after clears that leave an error register empty.

// File: rtl/qisr_pkg.sv
package qisr_pkg;
  localparam int REG_ADDR_W = 4;
  localparam int REG_W      = 32;
  localparam int HALF_W     = 16;
  localparam int EXC_W      = 5;

  localparam logic [REG_ADDR_W-1:0] RA_DONE_STAT = 4'd0;
  localparam logic [REG_ADDR_W-1:0] RA_DONE_EN   = 4'd1;
  localparam logic [REG_ADDR_W-1:0] RA_EXC_STAT  = 4'd2;
  localparam logic [REG_ADDR_W-1:0] RA_EXC_EN    = 4'd3;
  localparam logic [REG_ADDR_W-1:0] RA_TXERR     = 4'd4;
  localparam logic [REG_ADDR_W-1:0] RA_TXERR_EN  = 4'd5;
  localparam logic [REG_ADDR_W-1:0] RA_RXERR0    = 4'd6;
  localparam logic [REG_ADDR_W-1:0] RA_RXERR0_EN = 4'd7;
  localparam logic [REG_ADDR_W-1:0] RA_RXERR1    = 4'd8;
  localparam logic [REG_ADDR_W-1:0] RA_RXERR1_EN = 4'd9;

  // summary bit positions
  localparam int EXB_RX_CS  = 0;
  localparam int EXB_RX_LEN = 1;
  localparam int EXB_RX_ZLP = 2;
  localparam int EXB_TX_CS  = 3;
  localparam int EXB_TX_LEN = 4;

  // queue endpoints are 1 .. n-1; endpoint 0 is never a queue
  function automatic logic [HALF_W-1:0] queue_ep_mask(input int n);
    logic [HALF_W-1:0] m;
    m = '0;
    for (int i = 1; i < HALF_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/qisr_w1c_bank.sv
module qisr_w1c_bank #(
  parameter int           W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] gate_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic [W-1:0] set_ok;
  logic         upd;

  always_comb begin
    set_ok = set_i & gate_i & MASK;
    // set has priority over a same-cycle clear
    q_d    = (q_q & ~clr_i) | set_ok;
    upd    = (|set_ok) | (|(clr_i & q_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (upd) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/qisr_rw_reg.sv
module qisr_rw_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;

  always_comb begin
    q_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (we_i) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/qisr_irq_reduce.sv
module qisr_irq_reduce
  import qisr_pkg::*;
(
  input  logic [REG_W-1:0]  done_q_i,
  input  logic [REG_W-1:0]  done_en_i,
  input  logic [REG_W-1:0]  txerr_i,
  input  logic [REG_W-1:0]  rxerr0_i,
  input  logic [HALF_W-1:0] rxerr1_i,
  input  logic [EXC_W-1:0]  exc_en_i,
  output logic [EXC_W-1:0]  exc_o,
  output logic              irq_o
);
  always_comb begin
    exc_o             = '0;
    exc_o[EXB_RX_CS]  = |rxerr0_i[HALF_W-1:0];
    exc_o[EXB_RX_LEN] = |rxerr0_i[REG_W-1:HALF_W];
    exc_o[EXB_RX_ZLP] = |rxerr1_i;
    exc_o[EXB_TX_CS]  = |txerr_i[HALF_W-1:0];
    exc_o[EXB_TX_LEN] = |txerr_i[REG_W-1:HALF_W];
    irq_o = (|(done_q_i & done_en_i)) | (|(exc_o & exc_en_i));
  end
endmodule

// File: rtl/qisr_aggregator.sv
module qisr_aggregator
  import qisr_pkg::*;
#(
  parameter int NUM_EP = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EP-1:0]     tx_done_evt,
  input  logic [NUM_EP-1:0]     rx_done_evt,
  input  logic [NUM_EP-1:0]     tx_cs_err_evt,
  input  logic [NUM_EP-1:0]     tx_len_err_evt,
  input  logic [NUM_EP-1:0]     rx_cs_err_evt,
  input  logic [NUM_EP-1:0]     rx_len_err_evt,
  input  logic [NUM_EP-1:0]     rx_zlp_evt,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  irq
);
  localparam logic [HALF_W-1:0] EP_MASK   = queue_ep_mask(NUM_EP);
  localparam logic [REG_W-1:0]  PAIR_MASK = {EP_MASK, EP_MASK};

  logic [HALF_W-1:0] tx_done_pad, rx_done_pad, tx_cs_pad, tx_len_pad;
  logic [HALF_W-1:0] rx_cs_pad, rx_len_pad, rx_zlp_pad;

  always_comb begin
    tx_done_pad = '0; rx_done_pad = '0; tx_cs_pad = '0; tx_len_pad = '0;
    rx_cs_pad   = '0; rx_len_pad  = '0; rx_zlp_pad = '0;
    tx_done_pad[NUM_EP-1:0] = tx_done_evt;
    rx_done_pad[NUM_EP-1:0] = rx_done_evt;
    tx_cs_pad[NUM_EP-1:0]   = tx_cs_err_evt;
    tx_len_pad[NUM_EP-1:0]  = tx_len_err_evt;
    rx_cs_pad[NUM_EP-1:0]   = rx_cs_err_evt;
    rx_len_pad[NUM_EP-1:0]  = rx_len_err_evt;
    rx_zlp_pad[NUM_EP-1:0]  = rx_zlp_evt;
  end

  // write decode
  logic we_done_en, we_exc_en, we_txerr_en, we_rxerr0_en, we_rxerr1_en;
  logic [REG_W-1:0]  clr_done, clr_txerr, clr_rxerr0;
  logic [HALF_W-1:0] clr_rxerr1;

  always_comb begin
    we_done_en   = reg_wr && (reg_addr == RA_DONE_EN);
    we_exc_en    = reg_wr && (reg_addr == RA_EXC_EN);
    we_txerr_en  = reg_wr && (reg_addr == RA_TXERR_EN);
    we_rxerr0_en = reg_wr && (reg_addr == RA_RXERR0_EN);
    we_rxerr1_en = reg_wr && (reg_addr == RA_RXERR1_EN);
    clr_done   = (reg_wr && reg_addr == RA_DONE_STAT) ? reg_wdata : '0;
    clr_txerr  = (reg_wr && reg_addr == RA_TXERR)     ? reg_wdata : '0;
    clr_rxerr0 = (reg_wr && reg_addr == RA_RXERR0)    ? reg_wdata : '0;
    clr_rxerr1 = (reg_wr && reg_addr == RA_RXERR1)    ? reg_wdata[HALF_W-1:0] : '0;
  end

  // enable registers
  logic [REG_W-1:0]  done_en_q, txerr_en_q, rxerr0_en_q;
  logic [HALF_W-1:0] rxerr1_en_q;
  logic [EXC_W-1:0]  exc_en_q;

  qisr_rw_reg #(.W(REG_W)) u_done_en (
    .clk(clk), .rst_n(rst_n), .we_i(we_done_en), .wdata_i(reg_wdata), .q_o(done_en_q));
  qisr_rw_reg #(.W(EXC_W)) u_exc_en (
    .clk(clk), .rst_n(rst_n), .we_i(we_exc_en), .wdata_i(reg_wdata[EXC_W-1:0]), .q_o(exc_en_q));
  qisr_rw_reg #(.W(REG_W)) u_txerr_en (
    .clk(clk), .rst_n(rst_n), .we_i(we_txerr_en), .wdata_i(reg_wdata), .q_o(txerr_en_q));
  qisr_rw_reg #(.W(REG_W)) u_rxerr0_en (
    .clk(clk), .rst_n(rst_n), .we_i(we_rxerr0_en), .wdata_i(reg_wdata), .q_o(rxerr0_en_q));
  qisr_rw_reg #(.W(HALF_W)) u_rxerr1_en (
    .clk(clk), .rst_n(rst_n), .we_i(we_rxerr1_en), .wdata_i(reg_wdata[HALF_W-1:0]), .q_o(rxerr1_en_q));

  // status banks
  logic [REG_W-1:0]  done_q, txerr_q, rxerr0_q;
  logic [HALF_W-1:0] rxerr1_q;
  logic [REG_W-1:0]  done_set, txerr_set, rxerr0_set;

  always_comb begin
    done_set   = {rx_done_pad, tx_done_pad};
    txerr_set  = {tx_len_pad, tx_cs_pad};
    rxerr0_set = {rx_len_pad, rx_cs_pad};
  end

  qisr_w1c_bank #(.W(REG_W), .MASK(PAIR_MASK)) u_done (
    .clk(clk), .rst_n(rst_n), .set_i(done_set), .gate_i('1),
    .clr_i(clr_done), .q_o(done_q));
  qisr_w1c_bank #(.W(REG_W), .MASK(PAIR_MASK)) u_txerr (
    .clk(clk), .rst_n(rst_n), .set_i(txerr_set), .gate_i(txerr_en_q),
    .clr_i(clr_txerr), .q_o(txerr_q));
  qisr_w1c_bank #(.W(REG_W), .MASK(PAIR_MASK)) u_rxerr0 (
    .clk(clk), .rst_n(rst_n), .set_i(rxerr0_set), .gate_i(rxerr0_en_q),
    .clr_i(clr_rxerr0), .q_o(rxerr0_q));
  qisr_w1c_bank #(.W(HALF_W), .MASK(EP_MASK)) u_rxerr1 (
    .clk(clk), .rst_n(rst_n), .set_i(rx_zlp_pad), .gate_i(rxerr1_en_q),
    .clr_i(clr_rxerr1), .q_o(rxerr1_q));

  logic [EXC_W-1:0] exc_stat;

  qisr_irq_reduce u_reduce (
    .done_q_i(done_q), .done_en_i(done_en_q), .txerr_i(txerr_q),
    .rxerr0_i(rxerr0_q), .rxerr1_i(rxerr1_q), .exc_en_i(exc_en_q),
    .exc_o(exc_stat), .irq_o(irq));

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_DONE_STAT: reg_rdata = done_q;
      RA_DONE_EN:   reg_rdata = done_en_q;
      RA_EXC_STAT:  reg_rdata[EXC_W-1:0] = exc_stat;
      RA_EXC_EN:    reg_rdata[EXC_W-1:0] = exc_en_q;
      RA_TXERR:     reg_rdata = txerr_q;
      RA_TXERR_EN:  reg_rdata = txerr_en_q;
      RA_RXERR0:    reg_rdata = rxerr0_q;
      RA_RXERR0_EN: reg_rdata = rxerr0_en_q;
      RA_RXERR1:    reg_rdata[HALF_W-1:0] = rxerr1_q;
      RA_RXERR1_EN: reg_rdata[HALF_W-1:0] = rxerr1_en_q;
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qisr_checker.sv
module qisr_checker
  import qisr_pkg::*;
#(
  parameter int NUM_EP = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [REG_ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]      reg_wdata,
  input logic [REG_W-1:0]      done_set,
  input logic [REG_W-1:0]      done_q,
  input logic [REG_W-1:0]      done_en_q,
  input logic [REG_W-1:0]      txerr_q,
  input logic [REG_W-1:0]      txerr_en_q,
  input logic [EXC_W-1:0]      exc_en_q,
  input logic [EXC_W-1:0]      exc_stat,
  input logic                  irq
);
  localparam logic [HALF_W-1:0] EPM = queue_ep_mask(NUM_EP);
  logic [REG_W-1:0] want_set;
  logic [REG_W-1:0] wr_clear;

  always_comb begin
    want_set = done_set & {EPM, EPM};
    wr_clear = (reg_wr && reg_addr == RA_DONE_STAT) ? reg_wdata : '0;
  end

  AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((done_q & $past(want_set)) == $past(want_set))); // R9
  AST_DONE_W1C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(done_q) & ~done_q & ~$past(wr_clear)) == '0)); // R2
  AST_TXERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((txerr_q & ~$past(txerr_q) & ~$past(txerr_en_q)) == '0)); // R4
  AST_EP0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q[0] == 1'b0 && done_q[HALF_W] == 1'b0 &&
     txerr_q[0] == 1'b0 && txerr_q[HALF_W] == 1'b0)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_en_q == '0 && exc_en_q == '0) |-> !irq); // R3
  AST_TX_SUMMARY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (txerr_q == '0) |-> (exc_stat[EXB_TX_LEN:EXB_TX_CS] == 2'b00)); // R6
endmodule

bind qisr_aggregator qisr_checker #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .done_set(done_set), .done_q(done_q),
  .done_en_q(done_en_q), .txerr_q(txerr_q), .txerr_en_q(txerr_en_q),
  .exc_en_q(exc_en_q), .exc_stat(exc_stat), .irq(irq));

// File: tb/sim_qisr_aggregator.sv
module sim_qisr_aggregator;
  localparam int NEP = 16;

  logic clk, rst_n;
  logic [NEP-1:0] tx_done, rx_done, tx_cs, tx_len, rx_cs, rx_len, rx_zlp;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;

  qisr_aggregator #(.NUM_EP(NEP)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_done_evt(tx_done), .rx_done_evt(rx_done),
    .tx_cs_err_evt(tx_cs), .tx_len_err_evt(tx_len), .rx_cs_err_evt(rx_cs),
    .rx_len_err_evt(rx_len), .rx_zlp_evt(rx_zlp), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  // model
  logic [31:0] m_done, m_den, m_tx, m_txen, m_rx0, m_rx0en;
  logic [15:0] m_rx1, m_rx1en, mk;
  logic [4:0]  m_exen;

  // scoreboard queues
  logic [3:0]  q_a[$];
  logic [31:0] q_d[$];
  logic        q_i[$];
  string       q_t[$];

  function automatic logic [4:0] m_exc();
    return {|m_tx[31:16], |m_tx[15:0], |m_rx1, |m_rx0[31:16], |m_rx0[15:0]};
  endfunction

  function automatic logic [31:0] m_reg(input logic [3:0] a);
    case (a)
      4'd0: return m_done;
      4'd1: return m_den;
      4'd2: return {27'd0, m_exc()};
      4'd3: return {27'd0, m_exen};
      4'd4: return m_tx;
      4'd5: return m_txen;
      4'd6: return m_rx0;
      4'd7: return m_rx0en;
      4'd8: return {16'd0, m_rx1};
      4'd9: return {16'd0, m_rx1en};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_irq();
    return (|(m_done & m_den)) | (|(m_exc() & m_exen));
  endfunction

  task automatic drive(input logic [15:0] td, rd, tc, tl, rc, rl, rz,
                       input logic wr, input logic [3:0] a, input logic [31:0] d);
    logic [31:0] s_done, s_tx, s_rx0;
    logic [15:0] s_rx1;
    @(negedge clk);
    tx_done = td; rx_done = rd; tx_cs = tc; tx_len = tl;
    rx_cs = rc; rx_len = rl; rx_zlp = rz;
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    s_done = {rd & mk, td & mk};
    s_tx   = {tl & mk, tc & mk} & m_txen;
    s_rx0  = {rl & mk, rc & mk} & m_rx0en;
    s_rx1  = rz & mk & m_rx1en;
    if (wr) begin
      case (a)
        4'd0: m_done  = m_done & ~d;
        4'd1: m_den   = d;
        4'd3: m_exen  = d[4:0];
        4'd4: m_tx    = m_tx & ~d;
        4'd5: m_txen  = d;
        4'd6: m_rx0   = m_rx0 & ~d;
        4'd7: m_rx0en = d;
        4'd8: m_rx1   = m_rx1 & ~d[15:0];
        4'd9: m_rx1en = d[15:0];
        default: ;
      endcase
    end
    m_done = m_done | s_done;
    m_tx   = m_tx | s_tx;
    m_rx0  = m_rx0 | s_rx0;
    m_rx1  = m_rx1 | s_rx1;
    @(negedge clk);
    tx_done = '0; rx_done = '0; tx_cs = '0; tx_len = '0;
    rx_cs = '0; rx_len = '0; rx_zlp = '0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    drive('0, '0, '0, '0, '0, '0, '0, 1'b1, a, d);
  endtask

  task automatic check(input logic [3:0] a, input string tag);
    @(negedge clk);
    reg_addr = a;
    q_a.push_back(a); q_d.push_back(m_reg(a)); q_i.push_back(m_irq()); q_t.push_back(tag);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_a.size() > 0) begin
        logic [3:0] a; logic [31:0] d; logic i; string t;
        a = q_a.pop_front(); d = q_d.pop_front(); i = q_i.pop_front(); t = q_t.pop_front();
        checks++;
        if (reg_rdata !== d) begin
          fails++;
          $display("FAIL %s idx=%0d rdata actual=%h expected=%h", t, a, reg_rdata, d);
        end
        checks++;
        if (irq !== i) begin
          fails++;
          $display("FAIL %s irq actual=%b expected=%b", t, irq, i);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    mk = '0;
    for (int i = 1; i < NEP; i++) mk[i] = 1'b1;
    m_done = '0; m_den = '0; m_tx = '0; m_txen = '0; m_rx0 = '0; m_rx0en = '0;
    m_rx1 = '0; m_rx1en = '0; m_exen = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    tx_done = '0; rx_done = '0; tx_cs = '0; tx_len = '0;
    rx_cs = '0; rx_len = '0; rx_zlp = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 10; a++) check(a[3:0], "R11 reset");

    drive(16'h0008, 16'h0020, '0, '0, '0, '0, '0, 1'b0, 4'd0, '0);
    check(4'd0, "R1 done packing");

    wr(4'd0, 32'h0);
    check(4'd0, "R2 write zero keeps");
    wr(4'd0, 32'h0000_0008);
    check(4'd0, "R2 write one clears");

    wr(4'd1, 32'h0020_0000);
    check(4'd1, "R3 done enable match");
    wr(4'd1, 32'h0000_0008);
    check(4'd0, "R3 done enable mismatch");

    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF);
    check(4'd9, "R10 rx1 enable width");
    drive(16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b0, 4'd0, '0);
    check(4'd0, "R8 ep0 done");
    check(4'd4, "R8 ep0 tx err");
    check(4'd6, "R8 ep0 rx err0");
    check(4'd8, "R8 ep0 rx err1");

    wr(4'd5, 32'h0000_0004);
    drive('0, '0, 16'h0044, 16'h0004, '0, '0, '0, 1'b0, 4'd0, '0);
    check(4'd4, "R4 gated tx errors");
    wr(4'd5, 32'hFFFF_FFFF);
    drive('0, '0, '0, 16'h0080, '0, '0, '0, 1'b0, 4'd0, '0);
    check(4'd4, "R4 tx length error");

    drive('0, '0, '0, '0, 16'h0010, '0, 16'h0200, 1'b0, 4'd0, '0);
    check(4'd6, "R5 rx cs kept apart from zlp");
    check(4'd8, "R5 rx zlp register");
    wr(4'd9, 32'h0000_0000);
    drive('0, '0, '0, '0, '0, 16'h0002, 16'h0400, 1'b0, 4'd0, '0);
    check(4'd6, "R5 rx length error");
    check(4'd8, "R5 zlp gated off");
    wr(4'd9, 32'h0000_FFFF);

    check(4'd2, "R6 summary all set");
    wr(4'd2, 32'hFFFF_FFFF);
    check(4'd2, "R6 summary read only");

    wr(4'd1, 32'h0);
    check(4'd3, "R7 no enables");
    wr(4'd3, 32'h0000_0004);
    check(4'd3, "R7 zlp enable raises irq");
    wr(4'd3, 32'hFFFF_FFFF);
    check(4'd3, "R10 exc enable width");

    wr(4'd8, 32'h0000_0200);
    check(4'd2, "R6 zlp summary drops");
    wr(4'd4, 32'hFFFF_FFFF);
    check(4'd2, "R6 tx summary drops");
    wr(4'd3, 32'h0000_0004);
    check(4'd3, "R7 enabled summary cleared");

    drive(16'h0008, '0, '0, '0, '0, '0, '0, 1'b1, 4'd0, 32'h0020_0008);
    check(4'd0, "R9 set wins over clear");

    check(4'd12, "R11 unmapped index");
    check(4'd5, "R10 tx enable readback");

    repeat (3) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule